// File: doc/BRIEF.md
# Interrupt Pending State Tracker

This block decides, for each of 256 interrupt aggregation rings, whether a ring write should raise an interrupt message. Each ring context holds one state bit, either waiting for a trigger or service routine running, and a stored producer index. The ring writer reports each producer-index advance as an event. The first such event on a waiting ring raises an interrupt and marks the ring as running. Events on a ring that is already running only move the stored index.

Software reports how far it has read with a consumer-index write that names the ring. The block compares the written consumer index with the stored producer index. If they are equal, the ring goes back to waiting. If they differ, software has not yet read everything, so the block raises the interrupt again to make software reread the ring.

Interrupt requests collect in a per-ring pending set, so several requests for one ring merge into one. One request leaves per cycle as a valid pulse with a ring number. Among the pending rings, the lowest-numbered one goes first.

Top module: `intr_pend_tracker`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `irq_vld` is 0. Reset leaves every ring in the waiting state (0) with a stored producer index of 0 and nothing pending.
- R2: A producer event on a waiting ring stores `prod_pidx`, marks the ring running (1) and makes an interrupt request for it. When no lower ring is pending, `irq_vld` is 1 with `irq_ring` equal to that ring in the second cycle after the event.
- R3: A producer event on a running ring stores `prod_pidx` and makes no interrupt request.
- R4: A consumer write whose `cons_cidx` equals the ring's stored producer index returns the ring to waiting, so the next producer event on that ring raises an interrupt again.
- R5: A consumer write whose `cons_cidx` differs from the ring's stored producer index makes a new interrupt request for that ring and leaves the ring running. This holds whether the ring was waiting or running before the write.
- R6: A producer event and a consumer write to the same ring in one cycle are resolved in a fixed order. The producer event is applied first, including its request when the ring was waiting. The consumer compare then uses the new producer index.
- R7: At most one request leaves per cycle, and the lowest-numbered pending ring goes first. Requests for a ring that is already pending merge into one. The output goes idle only when nothing is pending.
- R8: The 8-bit ring number reaches all 256 contexts, including 0 and 255. The contexts are independent: an event on one ring changes no other ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prod_vld | input | 1 | Producer-index update event |
| prod_ring | input | 8 | Ring addressed by the producer event |
| prod_pidx | input | 12 | New producer index |
| cons_vld | input | 1 | Software consumer-index write |
| cons_ring | input | 8 | Ring addressed by the consumer write |
| cons_cidx | input | 12 | New consumer index from software |
| irq_vld | output | 1 | Interrupt request pulse |
| irq_ring | output | 8 | Ring the request belongs to |

## Verification
The assertions assume that the ring and index fields hold known values whenever their valid is high. Their triggers exclude the cycles in which a producer event and a consumer write hit the same ring, so each property follows one update path. The stimulus always drives defined values and draws rings from a small set that includes 0, 1, 254 and 255, which makes same-ring collisions and merged requests frequent. Indices come from a four-value range, so equal and unequal consumer compares both occur often.

// File: rtl/intr_trk_pkg.sv
package intr_trk_pkg;

    parameter int NUM_RINGS = 256;
    parameter int IDX_W     = 12;
    localparam int RING_W   = $clog2(NUM_RINGS);

    typedef logic [RING_W-1:0]    ring_t;
    typedef logic [IDX_W-1:0]     idx_t;
    typedef logic [NUM_RINGS-1:0] ring_vec_t;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_ISR  = 1'b1
    } int_st_e;

    typedef struct packed {
        logic  vld;
        ring_t ring;
        idx_t  idx;
    } ptr_evt_t;

    typedef struct packed {
        logic  found;
        ring_t ring;
    } pick_t;

    function automatic pick_t pick_lowest(input ring_vec_t v);
        pick_t p;
        p.found = 1'b0;
        p.ring  = '0;
        for (int i = NUM_RINGS - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.found = 1'b1;
                p.ring  = ring_t'(i);
            end
        end
        return p;
    endfunction

    function automatic ring_vec_t ring_onehot(input pick_t p);
        ring_vec_t m;
        m = '0;
        if (p.found) m[p.ring] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/trk_index_store.sv
module trk_index_store
    import intr_trk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ptr_evt_t prod_evt,
    input  ring_t    rd_ring,
    output idx_t     rd_pidx
);

    idx_t pidx_q [NUM_RINGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_RINGS; i++) pidx_q[i] <= '0;
        end else if (prod_evt.vld) begin
            pidx_q[prod_evt.ring] <= prod_evt.idx;
        end
    end

    assign rd_pidx = pidx_q[rd_ring];

endmodule

// File: rtl/trk_state_ctrl.sv
module trk_state_ctrl
    import intr_trk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ptr_evt_t  prod_evt,
    input  ptr_evt_t  cons_evt,
    input  idx_t      cons_pidx_cur,
    output ring_vec_t req_vec,
    output ring_vec_t st_vec
);

    ring_vec_t st_q;
    ring_vec_t st_d;
    logic      same_ring;
    idx_t      cons_ref;
    logic      cons_match;

    // producer update lands first; the consumer compare sees its new index
    assign same_ring  = prod_evt.vld && cons_evt.vld && (prod_evt.ring == cons_evt.ring);
    assign cons_ref   = same_ring ? prod_evt.idx : cons_pidx_cur;
    assign cons_match = (cons_evt.idx == cons_ref);

    for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ctx
        logic p_hit;
        logic c_hit;
        logic waiting;
        assign p_hit   = prod_evt.vld && (prod_evt.ring == ring_t'(r));
        assign c_hit   = cons_evt.vld && (cons_evt.ring == ring_t'(r));
        assign waiting = (int_st_e'(st_q[r]) == ST_WAIT);

        assign req_vec[r] = (p_hit && waiting) || (c_hit && !cons_match);

        always_comb begin
            if (c_hit)
                st_d[r] = cons_match ? ST_WAIT : ST_ISR;
            else if (p_hit)
                st_d[r] = ST_ISR;
            else
                st_d[r] = st_q[r];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign st_vec = st_q;

endmodule

// File: rtl/trk_req_arbiter.sv
module trk_req_arbiter
    import intr_trk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ring_vec_t req_vec,
    output ring_vec_t pend_vec,
    output logic      irq_vld,
    output ring_t     irq_ring
);

    ring_vec_t pend_q;
    ring_vec_t pend_d;
    pick_t     pick;

    assign pick   = pick_lowest(pend_q);
    assign pend_d = (pend_q & ~ring_onehot(pick)) | req_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= '0;
            irq_vld  <= 1'b0;
            irq_ring <= '0;
        end else begin
            pend_q   <= pend_d;
            irq_vld  <= pick.found;
            irq_ring <= pick.ring;
        end
    end

    assign pend_vec = pend_q;

endmodule

// File: rtl/intr_pend_tracker.sv
module intr_pend_tracker
    import intr_trk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        prod_vld,
    input  logic [7:0]  prod_ring,
    input  logic [11:0] prod_pidx,
    input  logic        cons_vld,
    input  logic [7:0]  cons_ring,
    input  logic [11:0] cons_cidx,
    output logic        irq_vld,
    output logic [7:0]  irq_ring
);

    ptr_evt_t  prod_evt;
    ptr_evt_t  cons_evt;
    idx_t      cons_pidx_cur;
    ring_vec_t req_vec;
    ring_vec_t st_vec;
    ring_vec_t pend_vec;
    ring_t     irq_ring_i;

    assign prod_evt = '{vld: prod_vld, ring: ring_t'(prod_ring), idx: idx_t'(prod_pidx)};
    assign cons_evt = '{vld: cons_vld, ring: ring_t'(cons_ring), idx: idx_t'(cons_cidx)};

    trk_index_store u_store (
        .clk      (clk),
        .rst      (rst),
        .prod_evt (prod_evt),
        .rd_ring  (cons_evt.ring),
        .rd_pidx  (cons_pidx_cur)
    );

    trk_state_ctrl u_state (
        .clk           (clk),
        .rst           (rst),
        .prod_evt      (prod_evt),
        .cons_evt      (cons_evt),
        .cons_pidx_cur (cons_pidx_cur),
        .req_vec       (req_vec),
        .st_vec        (st_vec)
    );

    trk_req_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .req_vec  (req_vec),
        .pend_vec (pend_vec),
        .irq_vld  (irq_vld),
        .irq_ring (irq_ring_i)
    );

    assign irq_ring = 8'(irq_ring_i);

endmodule

// File: rtl/intr_pend_tracker_chk.sv
module intr_pend_tracker_chk
    import intr_trk_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      prod_vld,
    input ring_t     prod_ring,
    input logic      cons_vld,
    input ring_t     cons_ring,
    input idx_t      cons_cidx,
    input idx_t      cons_pidx,
    input ring_vec_t st_q,
    input ring_vec_t pend_q,
    input logic      irq_vld,
    input ring_t     irq_ring
);

    ring_vec_t pend_prev;
    ring_vec_t low_mask;

    always_ff @(posedge clk) pend_prev <= pend_q;

    assign low_mask = ({{(NUM_RINGS-1){1'b0}}, 1'b1} << irq_ring) - 1'b1;

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!irq_vld && pend_q == '0 && st_q == '0));

    assert_trigger_sets_isr_R2: assert property (@(posedge clk) disable iff (rst)
        (prod_vld && !st_q[prod_ring] && !cons_vld)
        |=> (st_q[$past(prod_ring)] && pend_q[$past(prod_ring)]));

    assert_running_no_request_R3: assert property (@(posedge clk) disable iff (rst)
        (prod_vld && st_q[prod_ring] && !(cons_vld && cons_ring == prod_ring))
        |=> (st_q[$past(prod_ring)] &&
             (pend_q[$past(prod_ring)] ==
              ($past(pend_q[prod_ring]) && !(irq_vld && irq_ring == $past(prod_ring))))));

    assert_match_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (cons_vld && cons_cidx == cons_pidx && !(prod_vld && prod_ring == cons_ring))
        |=> !st_q[$past(cons_ring)]);

    assert_lag_refires_R5: assert property (@(posedge clk) disable iff (rst)
        (cons_vld && cons_cidx != cons_pidx && !(prod_vld && prod_ring == cons_ring))
        |=> (st_q[$past(cons_ring)] && pend_q[$past(cons_ring)]));

    assert_emit_pending_R7: assert property (@(posedge clk) disable iff (rst)
        irq_vld |-> pend_prev[irq_ring]);

    assert_emit_lowest_R7: assert property (@(posedge clk) disable iff (rst)
        irq_vld |-> ((pend_prev & low_mask) == '0));

    assert_idle_only_empty_R7: assert property (@(posedge clk) disable iff (rst)
        !irq_vld |-> (pend_prev == '0));

endmodule

bind intr_pend_tracker intr_pend_tracker_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .prod_vld  (prod_vld),
    .prod_ring (prod_evt.ring),
    .cons_vld  (cons_vld),
    .cons_ring (cons_evt.ring),
    .cons_cidx (cons_evt.idx),
    .cons_pidx (cons_pidx_cur),
    .st_q      (st_vec),
    .pend_q    (pend_vec),
    .irq_vld   (irq_vld),
    .irq_ring  (irq_ring_i)
);

// File: tb/test_intr_pend_tracker.sv
module test_intr_pend_tracker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prod_vld = 1'b0;
    logic [7:0]  prod_ring = '0;
    logic [11:0] prod_pidx = '0;
    logic        cons_vld = 1'b0;
    logic [7:0]  cons_ring = '0;
    logic [11:0] cons_cidx = '0;
    logic        irq_vld;
    logic [7:0]  irq_ring;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [11:0]  m_pidx [256];
    logic [255:0] m_st;
    logic [255:0] m_pend;

    always #10 clk = ~clk;

    intr_pend_tracker i_intr_pend_tracker (
        .clk(clk), .rst(rst),
        .prod_vld(prod_vld), .prod_ring(prod_ring), .prod_pidx(prod_pidx),
        .cons_vld(cons_vld), .cons_ring(cons_ring), .cons_cidx(cons_cidx),
        .irq_vld(irq_vld), .irq_ring(irq_ring)
    );

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                fails++;
                $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    function automatic int lowest(input logic [255:0] v);
        for (int i = 0; i < 256; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic step(input string tag, input bit pv, input int pr, input int pi,
                        input bit cv, input int cr, input int ci);
        bit exp_v;
        int exp_r;
        logic [255:0] nxt;
        @(negedge clk);
        prod_vld  = pv;  prod_ring = 8'(pr);  prod_pidx = 12'(pi);
        cons_vld  = cv;  cons_ring = 8'(cr);  cons_cidx = 12'(ci);
        exp_r = lowest(m_pend);
        exp_v = (exp_r >= 0);
        nxt = m_pend;
        if (exp_v) nxt[exp_r] = 1'b0;
        if (pv) begin
            if (!m_st[pr]) begin nxt[pr] = 1'b1; m_st[pr] = 1'b1; end
            m_pidx[pr] = 12'(pi);
        end
        if (cv) begin
            if (12'(ci) == m_pidx[cr]) m_st[cr] = 1'b0;
            else begin nxt[cr] = 1'b1; m_st[cr] = 1'b1; end
        end
        m_pend = nxt;
        @(posedge clk);
        #1;
        checks++;
        if (irq_vld !== exp_v || (exp_v && irq_ring !== 8'(exp_r))) begin
            fails++;
            $display("FAIL %s: irq_vld/irq_ring actual %0b/%0d expected %0b/%0d",
                     tag, irq_vld, irq_ring, exp_v, exp_r);
        end
    endtask

    task automatic idle(input string tag, input int n);
        for (int k = 0; k < n; k++) step(tag, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4021);
        for (int i = 0; i < 256; i++) m_pidx[i] = '0;
        m_st = '0;
        m_pend = '0;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (irq_vld !== 1'b0) begin
            fails++;
            $display("FAIL R1: irq_vld during reset actual %0b expected 0", irq_vld);
        end
        @(negedge clk);
        rst = 1'b0;
        idle("R1", 2);

        // R2: trigger on a waiting ring
        step("R2", 1, 5, 3, 0, 0, 0);
        idle("R2", 2);
        // R3: more writes while running stay silent
        step("R3", 1, 5, 4, 0, 0, 0);
        idle("R3", 2);
        // R5: consumer lags the producer -> re-fire
        step("R5", 0, 0, 0, 1, 5, 3);
        idle("R5", 2);
        // R4: consumer catches up -> waiting again, next event fires
        step("R4", 0, 0, 0, 1, 5, 4);
        step("R4", 1, 5, 6, 0, 0, 0);
        idle("R4", 2);
        step("R4", 0, 0, 0, 1, 5, 6);
        // R5: lagging write on a waiting ring also fires
        step("R5", 0, 0, 0, 1, 7, 9);
        idle("R5", 2);
        // R6: same ring, same cycle, matching new index
        step("R6", 1, 9, 2, 1, 9, 2);
        idle("R6", 2);
        step("R6", 1, 9, 3, 0, 0, 0);
        idle("R6", 2);
        // R6: same ring, same cycle, consumer behind the new index
        step("R6", 1, 9, 8, 1, 9, 3);
        idle("R6", 2);
        // R7: two rings in one cycle, lower one first, merge of repeats
        step("R7", 1, 200, 1, 1, 4, 1);
        step("R7", 0, 0, 0, 1, 200, 5);
        idle("R7", 3);
        // R8: extreme ring numbers are independent
        step("R8", 1, 255, 1, 0, 0, 0);
        step("R8", 1, 0, 1, 0, 0, 0);
        idle("R8", 3);
        step("R8", 0, 0, 0, 1, 0, 1);
        step("R8", 1, 0, 2, 0, 0, 0);
        idle("R8", 3);

        // R7: constrained random mix on a small ring set
        for (int n = 0; n < 4000; n++) begin
            int rs [6] = '{0, 1, 2, 3, 254, 255};
            bit pv = ($urandom % 3) != 0;
            bit cv = ($urandom % 3) == 0;
            int pr = rs[$urandom % 6];
            int cr = rs[$urandom % 6];
            int pi = int'($urandom % 4);
            int ci = int'($urandom % 4);
            step("R7", pv, pr, pi, cv, cr, ci);
        end
        idle("R7", 8);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule